// File: doc/BRIEF.md
# Level-Aware Interrupt Redirection Slice

This block sits between a set of interrupt input lines and a single outgoing interrupt message stream. Each input line has a redirection entry that holds an 8-bit vector, a trigger selection (edge or level) and a mask. When an entry wants service, the block sends the entry's vector and line number on a valid/ready output. Only one message is in flight at a time. When several entries are waiting, the lowest line index goes first.

Level-triggered entries keep a remote-in-service flag. The flag is set when the consumer accepts the entry's message, and while it is set the entry sends nothing more. Software clears the flag by writing a vector to an end-of-interrupt register. Every entry whose vector equals the written value has its flag cleared in the same cycle. This includes entries that share a vector with the one actually serviced. Clearing early is harmless: an entry whose input is still high sends its message again.

Software reaches the entries, the end-of-interrupt register and a small identification register through a plain write port and a combinational read port. Word addresses are: 0 for identification, 1 for end-of-interrupt, and 2+i for entry i.

Back-pressure on the message output: once `msg_valid` is high, it stays high, and `msg_line`/`msg_vector` stay unchanged, until a cycle with `msg_ready` high. The transfer completes on that clock edge. `msg_valid` is then low for at least one cycle before the next message.

Top module: `irq_redirect_unit`

## Requirements
- R1: After reset, `msg_valid` is low, the identification register reads 0, and every entry reads 0x200: masked, edge-triggered, vector 0, remote flag clear.
- R2: The identification register (address 0) stores a 4-bit ID in bits 27:24 and a scratch bit in bit 15. Both can be written and read back. All other bits read 0.
- R3: The end-of-interrupt register (address 1) is write-only and always reads 0. A write to it uses only bits 7:0 of the data as the vector.
- R4: Each entry reads as: bits 7:0 vector, bit 8 trigger (1 = level), bit 9 mask (1 = masked), bit 10 remote flag (read-only). An unmasked level entry with its input high and its flag clear sends one message. The flag is set when that message is accepted, and no further message leaves that entry while the flag is set.
- R5: An end-of-interrupt write clears the remote flag of every entry whose vector matches, in the same cycle. Bits 31:8 of the written data do not affect the match.
- R6: A level entry whose input is still high when its flag is cleared sends its message again.
- R7: An unmasked edge entry sends exactly one message per rising edge of its input and never sets its remote flag.
- R8: A masked entry sends nothing. Unmasking a level entry whose input is high and whose flag is clear makes it send a message.
- R9: Entries that are waiting at the same time are served lowest line index first, with at most one message outstanding.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_line` and `msg_vector` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Interrupt input lines, synchronous to clk |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | ADDR_W | Register read word address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| msg_valid | output | 1 | Interrupt message valid |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Vector of the outgoing message |
| msg_line | output | $clog2(NUM_LINES) | Entry index of the outgoing message |

## Verification
The bench targets the following corner cases:
- **Two level entries sharing one vector.** One end-of-interrupt write must clear both flags. A design that cleared only the first match would leave the idle entry's flag set.
- **Early clear with the input still high.** The flag is cleared while the input is still asserted. A design that lost the interrupt would never send a second message, which leaves an unmatched expectation in the scoreboard.
- **Held level input and held edge input.** A design that ignored the flag, or that treated an edge entry as level, would send extra messages, and the monitor reports these as unexpected.
- **Stalled consumer, simultaneous requests, masked line.** These expose a payload that changes while stalled, a wrong service order, or a masked line that leaks a message.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int VEC_W       = 8;
  localparam int DATA_W      = 32;
  localparam int ID_W        = 4;
  localparam int ID_LSB      = 24;
  localparam int SCRATCH_BIT = 15;
  localparam int LVL_BIT     = 8;
  localparam int MSK_BIT     = 9;
  localparam int RFLAG_BIT   = 10;

  typedef struct packed {
    logic             masked;
    logic             level;
    logic [VEC_W-1:0] vector;
  } entry_cfg_t;

  localparam entry_cfg_t CFG_RESET = '{masked: 1'b1, level: 1'b0, vector: '0};
endpackage

// File: rtl/irq_entry.sv
module irq_entry
  import irq_redir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_in,
  input  logic             cfg_we,
  input  entry_cfg_t       cfg_wdata,
  input  logic             eoi_we,
  input  logic [VEC_W-1:0] eoi_vec,
  input  logic             accept,
  output entry_cfg_t       cfg_q,
  output logic             rflag_q,
  output logic             req
);
  logic prev_q, pend_q, rise, eoi_hit;

  assign rise    = irq_in & ~prev_q;
  assign eoi_hit = eoi_we && (eoi_vec == cfg_q.vector);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
      rflag_q <= 1'b0;
    end else begin
      prev_q <= irq_in;
      if (cfg_we) cfg_q <= cfg_wdata;
      // edge capture: a new edge wins over a same-cycle acceptance
      if (!cfg_q.level && !cfg_q.masked && rise) pend_q <= 1'b1;
      else if (accept || cfg_q.level || cfg_q.masked) pend_q <= 1'b0;
      // remote flag: meaningful only in level mode; set wins over clear
      if (!cfg_q.level) rflag_q <= 1'b0;
      else if (accept) rflag_q <= 1'b1;
      else if (eoi_hit) rflag_q <= 1'b0;
    end
  end

  assign req = ~cfg_q.masked & (cfg_q.level ? (irq_in & ~rflag_q) : pend_q);

  // R4: acceptance of a level message sets the flag
  a_r4_flag_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cfg_q.level |=> rflag_q);
  // R5: a matching end-of-interrupt clears the flag
  a_r5_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit && !accept |=> !rflag_q);
  // R7: edge entries never hold the flag
  a_r7_edge_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.level |=> !rflag_q);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  // R9: at most one winner, and only among requesters
  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r9_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 4,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_wr_addr,
  input  logic [DATA_W-1:0]    reg_wr_data,
  input  logic [ADDR_W-1:0]    reg_rd_addr,
  output logic [DATA_W-1:0]    reg_rd_data,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [VEC_W-1:0]     msg_vector,
  output logic [LINE_W-1:0]    msg_line
);
  localparam int ADDR_ID    = 0;
  localparam int ADDR_EOI   = 1;
  localparam int ENTRY_BASE = 2;

  entry_cfg_t           cfg_arr [NUM_LINES];
  logic [NUM_LINES-1:0] rflag, req, accept, cfg_we, grant;
  logic                 pick_any, eoi_we;
  logic [LINE_W-1:0]    pick_idx;
  logic [ID_W-1:0]      id_q;
  logic                 scratch_q;
  entry_cfg_t           cfg_wdata;
  logic                 unused_wr_bits;

  assign eoi_we    = reg_wr_en && (reg_wr_addr == ADDR_W'(ADDR_EOI));
  assign cfg_wdata = '{masked: reg_wr_data[MSK_BIT], level: reg_wr_data[LVL_BIT],
                       vector: reg_wr_data[VEC_W-1:0]};
  assign unused_wr_bits = ^{reg_wr_data[31:28], reg_wr_data[23:16], reg_wr_data[14:10]};

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_entry
      assign cfg_we[i] = reg_wr_en && (reg_wr_addr == ADDR_W'(ENTRY_BASE + i));
      assign accept[i] = msg_valid && msg_ready && (msg_line == LINE_W'(i));
      irq_entry u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in[i]),
        .cfg_we    (cfg_we[i]),
        .cfg_wdata (cfg_wdata),
        .eoi_we    (eoi_we),
        .eoi_vec   (reg_wr_data[VEC_W-1:0]),
        .accept    (accept[i]),
        .cfg_q     (cfg_arr[i]),
        .rflag_q   (rflag[i]),
        .req       (req[i])
      );
    end
  endgenerate

  irq_prio_pick #(.N(NUM_LINES)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant),
    .any   (pick_any),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q      <= '0;
      scratch_q <= 1'b0;
    end else if (reg_wr_en && reg_wr_addr == ADDR_W'(ADDR_ID)) begin
      id_q      <= reg_wr_data[ID_LSB +: ID_W];
      scratch_q <= reg_wr_data[SCRATCH_BIT];
    end
  end

  // one message in flight; a launch needs an idle cycle after each transfer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_line   <= '0;
      msg_vector <= '0;
    end else if (!msg_valid) begin
      if (pick_any) begin
        msg_valid  <= 1'b1;
        msg_line   <= pick_idx;
        msg_vector <= cfg_arr[pick_idx].vector;
      end
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  always_comb begin
    reg_rd_data = '0;
    if (reg_rd_addr == ADDR_W'(ADDR_ID))
      reg_rd_data = {4'b0, id_q, 8'b0, scratch_q, 15'b0};
    for (int i = 0; i < NUM_LINES; i++) begin
      if (reg_rd_addr == ADDR_W'(ENTRY_BASE + i))
        reg_rd_data = {21'b0, rflag[i], cfg_arr[i].masked, cfg_arr[i].level, cfg_arr[i].vector};
    end
  end

  // R10: a stalled message keeps its payload
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_line) && $stable(msg_vector));
  // R9: a completed transfer is followed by an idle cycle
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);
  // R9: only a line with a pending request may launch
  a_r9_launch_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid && !pick_any |=> !msg_valid);
endmodule

// File: tb/tb_irq_redirect_unit.sv
module tb_irq_redirect_unit;
  localparam int N = 8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [3:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_line;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_redirect_unit dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_line(msg_line)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    tick(1);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    tick(1);
    reg_wr_en = 1'b0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_check(logic [3:0] a, logic [31:0] exp, string tag);
    tick(1);
    reg_rd_addr = a;
    @(negedge clk);
    check(tag, reg_rd_data, exp);
  endtask

  task automatic expect_msg(int line, logic [7:0] vec, string tag);
    exp_q.push_back({3'(line), vec});
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4/R7/R8 unexpected message: actual line %0d vec %h expected none",
                 msg_line, msg_vector);
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {21'b0, msg_line, msg_vector}, {21'b0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1 valid", {31'b0, msg_valid}, 32'h0);
    rd_check(4'd0, 32'h0, "R1 ident");
    rd_check(4'd2, 32'h200, "R1 entry0");
    rd_check(4'd9, 32'h200, "R1 entry7");

    // R2: ident fields
    wr(4'd0, 32'hFFFF_FFFF);
    rd_check(4'd0, 32'h0F00_8000, "R2 ident ones");
    wr(4'd0, 32'h0500_0000);
    rd_check(4'd0, 32'h0500_0000, "R2 ident id only");
    // R3: eoi reads zero
    wr(4'd1, 32'hFFFF_FFFF);
    rd_check(4'd1, 32'h0, "R3 eoi read");

    // R4 / R5 / R6: level entry 2
    wr(4'd4, 32'h142);
    expect_msg(2, 8'h42, "R4 level message");
    irq_in[2] = 1'b1;
    tick(10);
    rd_check(4'd4, 32'h542, "R4 flag set");
    expect_msg(2, 8'h42, "R6 reissue after eoi");
    wr(4'd1, 32'hABCD_EF42);  // R5 upper bits ignored
    tick(10);
    irq_in[2] = 1'b0;
    wr(4'd1, 32'h42);
    rd_check(4'd4, 32'h142, "R5 flag cleared");

    // R10 / R9 / R5: shared vector entries 3 and 5
    wr(4'd5, 32'h155);
    wr(4'd7, 32'h155);
    msg_ready = 1'b0;
    expect_msg(3, 8'h55, "R9 lower first");
    expect_msg(5, 8'h55, "R9 higher second");
    irq_in[3] = 1'b1; irq_in[5] = 1'b1;
    tick(3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 hold", {20'b0, msg_valid, msg_line, msg_vector}, {20'b0, 1'b1, 3'd3, 8'h55});
    end
    tick(1);
    msg_ready = 1'b1;
    tick(10);
    rd_check(4'd7, 32'h555, "R4 entry5 flag");
    irq_in[5] = 1'b0;
    expect_msg(3, 8'h55, "R6 entry3 reissue");
    wr(4'd1, 32'h55);
    tick(10);
    rd_check(4'd7, 32'h155, "R5 shared clear");
    rd_check(4'd5, 32'h555, "R6 entry3 flag again");
    irq_in[3] = 1'b0;
    wr(4'd1, 32'h55);

    // R7: edge entry 6
    wr(4'd8, 32'h066);
    expect_msg(6, 8'h66, "R7 first edge");
    expect_msg(6, 8'h66, "R7 second edge");
    irq_in[6] = 1'b1; tick(3);
    irq_in[6] = 1'b0; tick(3);
    irq_in[6] = 1'b1; tick(12);
    rd_check(4'd8, 32'h066, "R7 no flag");
    irq_in[6] = 1'b0;

    // R8: mask
    wr(4'd3, 32'h311);
    irq_in[1] = 1'b1;
    tick(10);
    @(negedge clk);
    check("R8 masked quiet", {31'b0, msg_valid}, 32'h0);
    expect_msg(1, 8'h11, "R8 unmask issues");
    wr(4'd3, 32'h111);
    tick(10);
    irq_in[1] = 1'b0;
    wr(4'd1, 32'h11);

    // R9: simultaneous requests under stall
    wr(4'd2, 32'h110);
    wr(4'd6, 32'h144);
    msg_ready = 1'b0;
    expect_msg(0, 8'h10, "R9 entry0 first");
    expect_msg(4, 8'h44, "R9 entry4 second");
    irq_in[0] = 1'b1; irq_in[4] = 1'b1;
    tick(4);
    msg_ready = 1'b1;
    tick(10);
    irq_in[0] = 1'b0; irq_in[4] = 1'b0;
    wr(4'd1, 32'h10);
    wr(4'd1, 32'h44);
    tick(20);

    while (exp_q.size() != 0) begin
      logic [10:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++; fails++;
      $display("FAIL %s missing: actual none expected line %0d vec %h", t, e[10:8], e[7:0]);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule